// File: doc/BRIEF.md
# Window Watchdog with Lead Time

This block supervises a host processor. The processor must keep sending a trigger at a controlled rate. A trigger is either a rising edge on the positive trigger pin or a falling edge on the negative trigger pin. Each pin passes through a glitch filter that runs on the system clock. Timing is counted in ticks of a slow oscillator, which arrive as a one-cycle strobe.

After the reset output releases, the watchdog allows a long lead time for the first trigger. From then on it alternates between two windows. In the closed window a trigger is forbidden. In the open window a trigger is expected, and a trigger there starts a new closed window. A missed lead time, a missed open window or a trigger in the closed window each produce a reset pulse of fixed length. After that pulse the sequence starts again from the lead time.

The watchdog pulse is ANDed with an external undervoltage reset onto one active-low output. A mode controller can disable the watchdog, for example during low-power modes. While disabled, the watchdog issues no pulses.

Top module: `window_watchdog`

## Requirements
- R1: During and straight after the synchronous active-high `rst`, with `uv_reset_n` high, `rst_out_n` is high (1).
- R2: If no trigger is accepted within LEAD_TICKS oscillator ticks of the lead phase, `rst_out_n` goes low (0).
- R3: A watchdog pulse lasts PULSE_TICKS ticks. After it, `rst_out_n` returns high and a fresh lead phase begins, which produces a second pulse if it is also left untriggered.
- R4: A trigger accepted in the lead phase starts a closed window of CLOSED_TICKS ticks. That window is followed by an open window of OPEN_TICKS ticks. A trigger in the open window starts a new closed window. While triggers keep arriving in this way, `rst_out_n` stays high.
- R5: If no trigger is accepted before the open window expires, `rst_out_n` goes low.
- R6: A trigger accepted during the closed window drives `rst_out_n` low on the next clock cycle.
- R7: A rising edge on `pos_trig_i` and a falling edge on `neg_trig_i` are each a valid trigger. Edges on both pins in the same cycle count as a single trigger.
- R8: A pin level change that lasts fewer than FILT_CYCLES system clock cycles (after a 2-flop synchronizer) is ignored.
- R9: While `wd_enable` is low, no watchdog pulse is produced and the sequence is held at the start of the lead phase. Raising `wd_enable` starts a full lead phase.
- R10: While `uv_reset_n` is low, `rst_out_n` is low and the lead phase is held at its start. The lead phase is counted from the release of `uv_reset_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator period |
| wd_enable | input | 1 | Watchdog enable from the mode controller |
| uv_reset_n | input | 1 | Undervoltage reset, active low |
| pos_trig_i | input | 1 | Trigger pin, rising edge is active |
| neg_trig_i | input | 1 | Trigger pin, falling edge is active |
| rst_out_n | output | 1 | Combined reset output, active low |

## Verification
The bench applies several patterns. With no trigger at all, it checks that the lead phase expires, that the pulse has the right length and that the lead phase starts again. With regular triggers on each pin in turn, it checks that the output stays high only while that pin's edges are accepted, and then that the output falls once the open window is missed. An early trigger placed inside the closed window separates an immediate reset from a late one. A two-cycle glitch in the closed window separates a working filter from one that passes short pulses. Disable and undervoltage episodes show that the count is held and that the lead phase is measured from their release.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    typedef enum logic [1:0] {
        PH_LEAD   = 2'd0,
        PH_CLOSED = 2'd1,
        PH_OPEN   = 2'd2,
        PH_PULSE  = 2'd3
    } wd_phase_e;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Phase entered when the current phase runs out of ticks
    function automatic wd_phase_e phase_on_expiry(input wd_phase_e p);
        case (p)
            PH_LEAD:   return PH_PULSE;
            PH_CLOSED: return PH_OPEN;
            PH_OPEN:   return PH_PULSE;
            default:   return PH_LEAD;
        endcase
    endfunction

endpackage

// File: rtl/wwd_edge_filter.sv
module wwd_edge_filter #(
    parameter int unsigned FILT_CYCLES = 4,
    parameter bit          ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic edge_o
);
    localparam logic IDLE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;
    localparam int   FW       = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

    logic [1:0]    sync_q;
    logic          level_q;
    logic [FW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= {2{IDLE_LVL}};
            level_q <= IDLE_LVL;
            run_q   <= '0;
            edge_o  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            edge_o <= 1'b0;
            if (sync_q[1] == level_q) begin
                run_q <= '0;
            end else if (run_q == FW'(FILT_CYCLES - 1)) begin
                level_q <= sync_q[1];
                run_q   <= '0;
                edge_o  <= (sync_q[1] != IDLE_LVL);
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wwd_trig_front.sv
module wwd_trig_front #(
    parameter int unsigned FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pos_pin_i,
    input  logic neg_pin_i,
    output logic trig_o
);
    logic [1:0] pins;
    logic [1:0] edges;

    assign pins = {neg_pin_i, pos_pin_i};

    for (genvar i = 0; i < 2; i++) begin : g_pin
        wwd_edge_filter #(
            .FILT_CYCLES (FILT_CYCLES),
            .ACTIVE_HIGH (i == 0)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pins[i]),
            .edge_o (edges[i])
        );
    end

    // Same-cycle edges from both pins merge into one event
    assign trig_o = |edges;
endmodule

// File: rtl/wwd_window_seq.sv
module wwd_window_seq
    import wwd_pkg::*;
#(
    parameter int unsigned LEAD_TICKS   = 3922,
    parameter int unsigned CLOSED_TICKS = 800,
    parameter int unsigned OPEN_TICKS   = 840,
    parameter int unsigned PULSE_TICKS  = 157
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      hold_i,
    input  logic      tick_i,
    input  logic      trig_i,
    output wd_phase_e phase_o
);
    localparam int unsigned TOP = max_of4(LEAD_TICKS, CLOSED_TICKS, OPEN_TICKS, PULSE_TICKS);
    localparam int          CW  = $clog2(TOP + 1);

    typedef struct packed {
        wd_phase_e       phase;
        logic [CW-1:0]   cnt;
    } seq_state_t;

    seq_state_t    cur_q, nxt;
    logic [CW-1:0] last_cnt;

    always_comb begin
        case (cur_q.phase)
            PH_LEAD:   last_cnt = CW'(LEAD_TICKS - 1);
            PH_CLOSED: last_cnt = CW'(CLOSED_TICKS - 1);
            PH_OPEN:   last_cnt = CW'(OPEN_TICKS - 1);
            default:   last_cnt = CW'(PULSE_TICKS - 1);
        endcase
    end

    always_comb begin
        nxt = cur_q;
        if (hold_i) begin
            nxt.phase = PH_LEAD;
            nxt.cnt   = '0;
        end else if (trig_i && cur_q.phase != PH_PULSE) begin
            nxt.cnt   = '0;
            nxt.phase = (cur_q.phase == PH_CLOSED) ? PH_PULSE : PH_CLOSED;
        end else if (tick_i) begin
            if (cur_q.cnt == last_cnt) begin
                nxt.phase = phase_on_expiry(cur_q.phase);
                nxt.cnt   = '0;
            end else begin
                nxt.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.phase <= PH_LEAD;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign phase_o = cur_q.phase;
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wwd_pkg::*;
#(
    parameter int unsigned LEAD_TICKS   = 3922,
    parameter int unsigned CLOSED_TICKS = 800,
    parameter int unsigned OPEN_TICKS   = 840,
    parameter int unsigned PULSE_TICKS  = 157,
    parameter int unsigned FILT_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick_i,
    input  logic wd_enable,
    input  logic uv_reset_n,
    input  logic pos_trig_i,
    input  logic neg_trig_i,
    output logic rst_out_n
);
    logic      trig;
    logic      hold;
    wd_phase_e phase;

    assign hold = !wd_enable || !uv_reset_n;

    wwd_trig_front #(
        .FILT_CYCLES (FILT_CYCLES)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .pos_pin_i (pos_trig_i),
        .neg_pin_i (neg_trig_i),
        .trig_o    (trig)
    );

    wwd_window_seq #(
        .LEAD_TICKS   (LEAD_TICKS),
        .CLOSED_TICKS (CLOSED_TICKS),
        .OPEN_TICKS   (OPEN_TICKS),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .hold_i  (hold),
        .tick_i  (osc_tick_i),
        .trig_i  (trig),
        .phase_o (phase)
    );

    assign rst_out_n = uv_reset_n && (phase != PH_PULSE);
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker
    import wwd_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 157
) (
    input logic      clk,
    input logic      rst,
    input logic      osc_tick_i,
    input logic      wd_enable,
    input logic      uv_reset_n,
    input logic      trig,
    input wd_phase_e phase,
    input logic      rst_out_n
);
    int unsigned pulse_ticks;

    always_ff @(posedge clk) begin
        if (rst || phase != PH_PULSE) pulse_ticks <= 0;
        else if (osc_tick_i)          pulse_ticks <= pulse_ticks + 1;
    end

    a_r10_uv_forces_low: assert property (@(posedge clk) disable iff (rst)
        !uv_reset_n |-> !rst_out_n);

    a_r9_disable_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !wd_enable |=> (phase != PH_PULSE));

    a_r6_closed_trig_resets: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CLOSED && trig && wd_enable && uv_reset_n) |=> (phase == PH_PULSE));

    a_r4_open_trig_restarts: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OPEN && trig && wd_enable && uv_reset_n) |=> (phase == PH_CLOSED));

    a_r2_lead_exit: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LEAD && !trig) |=> (phase == PH_LEAD || phase == PH_PULSE));

    a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PULSE) |-> (pulse_ticks < PULSE_TICKS));
endmodule

bind window_watchdog wwd_checker #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .osc_tick_i (osc_tick_i),
    .wd_enable  (wd_enable),
    .uv_reset_n (uv_reset_n),
    .trig       (trig),
    .phase      (phase),
    .rst_out_n  (rst_out_n)
);

// File: tb/sim_window_watchdog.sv
module sim_window_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick_i = 1'b0;
    logic wd_enable = 1'b1;
    logic uv_reset_n = 1'b1;
    logic pos_trig_i = 1'b0;
    logic neg_trig_i = 1'b1;
    logic rst_out_n;

    int cyc = 0;
    int base = 0;
    int div = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    lvl;
        string tag;
    } exp_t;
    exp_t sb[$];
    exp_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        osc_tick_i = (div == 0);
        div = (div + 1) % TICK_DIV;
    end

    window_watchdog #(
        .LEAD_TICKS   (12),
        .CLOSED_TICKS (6),
        .OPEN_TICKS   (8),
        .PULSE_TICKS  (5),
        .FILT_CYCLES  (3)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .osc_tick_i (osc_tick_i),
        .wd_enable  (wd_enable),
        .uv_reset_n (uv_reset_n),
        .pos_trig_i (pos_trig_i),
        .neg_trig_i (neg_trig_i),
        .rst_out_n  (rst_out_n)
    );

    // Monitor: pops expected items when their cycle comes
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            cur = sb.pop_front();
            checks++;
            if (rst_out_n !== cur.lvl) begin
                failures++;
                $display("FAIL %s cycle %0d rst_out_n actual=%b expected=%b",
                         cur.tag, cyc, rst_out_n, cur.lvl);
            end
        end
    end

    task automatic expect_lvl(input int off, input bit lvl, input string tag);
        exp_t e;
        e.at = base + off;
        e.lvl = lvl;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_to(input int off);
        while (cyc < base + off) @(negedge clk);
    endtask

    // sel: 0 positive pin, 1 negative pin, 2 both
    task automatic pulse_pin(input int sel, input int at, input int len);
        wait_to(at);
        if (sel != 1) pos_trig_i = 1'b1;
        if (sel != 0) neg_trig_i = 1'b0;
        repeat (len) @(negedge clk);
        pos_trig_i = 1'b0;
        neg_trig_i = 1'b1;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pos_trig_i = 1'b0;
        neg_trig_i = 1'b1;
        wd_enable = 1'b1;
        uv_reset_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        base = cyc;
    endtask

    initial begin
        // R1: reset state
        @(negedge clk);
        base = cyc;
        expect_lvl(1, 1'b1, "R1");
        drain();

        // R2, R3: no triggers, lead expiry, pulse, restart
        do_reset();
        expect_lvl(0, 1'b1, "R1");
        expect_lvl(40, 1'b1, "R2");
        expect_lvl(56, 1'b0, "R2");
        expect_lvl(62, 1'b0, "R3");
        expect_lvl(76, 1'b1, "R3");
        expect_lvl(108, 1'b1, "R3");
        expect_lvl(124, 1'b0, "R3");
        drain();

        // R4, R5: regular triggers on positive pin, then stop
        do_reset();
        expect_lvl(70, 1'b1, "R4");
        expect_lvl(110, 1'b1, "R4");
        expect_lvl(140, 1'b1, "R4");
        expect_lvl(150, 1'b1, "R4");
        expect_lvl(165, 1'b0, "R5");
        pulse_pin(0, 20, 6);
        pulse_pin(0, 56, 6);
        pulse_pin(0, 96, 6);
        drain();

        // R6: trigger inside closed window
        do_reset();
        expect_lvl(24, 1'b1, "R6");
        expect_lvl(30, 1'b0, "R6");
        expect_lvl(40, 1'b0, "R6");
        pulse_pin(0, 10, 6);
        pulse_pin(0, 22, 6);
        drain();

        // R7: negative pin falling edges are triggers
        do_reset();
        expect_lvl(100, 1'b1, "R7");
        expect_lvl(125, 1'b0, "R7");
        pulse_pin(1, 20, 6);
        pulse_pin(1, 56, 6);
        drain();

        // R8: short glitch in closed window ignored; R7: both pins at once
        do_reset();
        expect_lvl(42, 1'b1, "R8");
        expect_lvl(90, 1'b1, "R7");
        pulse_pin(0, 20, 6);
        pulse_pin(0, 30, 2);
        pulse_pin(2, 56, 6);
        drain();

        // R9: disabled watchdog, then enable
        do_reset();
        wd_enable = 1'b0;
        expect_lvl(100, 1'b1, "R9");
        expect_lvl(200, 1'b1, "R9");
        expect_lvl(260, 1'b1, "R9");
        expect_lvl(276, 1'b0, "R9");
        wait_to(220);
        wd_enable = 1'b1;
        drain();

        // R10: undervoltage forces low and holds the lead phase
        do_reset();
        expect_lvl(7, 1'b0, "R10");
        expect_lvl(101, 1'b1, "R10");
        expect_lvl(140, 1'b1, "R10");
        expect_lvl(156, 1'b0, "R10");
        wait_to(5);
        uv_reset_n = 1'b0;
        wait_to(100);
        uv_reset_n = 1'b1;
        drain();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule